// File: doc/BRIEF.md
# Parallel Interleaver Index Generator

This block produces the internal permutation of a turbo code for one block of K bits, eight positions per clock. The permutation is the quadratic form pi(i) = (f1*i + f2*i^2) mod K. No pattern table is stored. A running index and a running increment are kept reduced modulo K. Inside one clock the eight lanes form a chain: each lane adds the increment to the index of the lane before it, then reduces the sum with a single compare-and-subtract. The increment itself advances by 2*f2 in the same way. Because every operand is already below K, one subtraction is always enough, so the datapath has no multiplier and no divider.

The caller writes the input block into a two-bank bit buffer, eight bits per word. It then pulses `start` with K, f1 and f2. The generator emits one word of eight indices per cycle. The same indices address the buffer, which returns the eight interleaved bits for the second constituent encoder one cycle later. While one bank is being read, the caller can fill the other bank with the next block.

Top module: `turbo_perm_gen`

## Requirements
- R1: After reset, `idxValid`, `idxLast`, `bitsValid` and `bitsLast` are low.
- R2: A `start` sampled while the generator is idle is accepted. The first index word is valid two clock edges after the edge that sampled `start`. Exactly K/8 words then follow, on consecutive cycles.
- R3: In word n, lane j (`idxWord[j*13 +: 13]`) carries pi(8n+j) = (f1*(8n+j) + f2*(8n+j)^2) mod K.
- R4: Every emitted index is below K. For a valid coefficient pair, each value 0..K-1 appears exactly once in the block.
- R5: `idxLast` is high only together with the final word, word K/8-1. After that word the generator emits nothing until the next accepted `start`.
- R6: A `start` pulse that arrives while a block is still being generated is ignored.
- R7: Bit p of the block is held in buffer word p/8, bit position p%8. `permBits[j]` carries the stored bit at position pi(8n+j) for word n. Bits are valid exactly one cycle after their index word, three edges after `start`, and `bitsLast` marks the final bit word.
- R8: Writes go to the fill bank. An accepted `start` makes the fill bank the read bank and swaps. Data written during a block therefore lands in the other bank and is read by the next block.
- R9: K may be any multiple of 8 from 8 to 6144. For K = 8 the single word carries both valid and last.
- R10: K, f1 and f2 are captured on the accepted `start`. Changes to those inputs during a block have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block (accepted when idle) |
| blkLen | input | 13 | Block length K, a multiple of 8 |
| coefF1 | input | 13 | Linear coefficient f1, below K |
| coefF2 | input | 13 | Quadratic coefficient f2, below K |
| wrEn | input | 1 | Write one 8-bit word into the fill bank |
| wrAddr | input | 10 | Word address of the write |
| wrData | input | 8 | Eight input bits, bit b at position 8*wrAddr+b |
| idxWord | output | 104 | Eight 13-bit indices, lane j at bits [13j+12:13j] |
| idxValid | output | 1 | Index word valid |
| idxLast | output | 1 | Final index word of the block |
| permBits | output | 8 | Eight interleaved bits |
| bitsValid | output | 1 | Interleaved bit word valid |
| bitsLast | output | 1 | Final bit word of the block |

## Verification
Results are timed from the clock edge that accepts `start`. Index word n is due after edge n+2 and bit word n after edge n+3. Both streams stay silent once the final word has passed. The bench model counts edges from each accepted start and compares every output at the falling edge, so each expected value is tied to one exact cycle. For every word it recomputes the closed-form permutation, and it checks the bits against its own copy of both buffer banks. Across each block it also checks that the index set is complete.

// File: rtl/turbo_perm_pkg.sv
package turbo_perm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_RUN
  } genStateT;

  // strobes from the sequencer to the index datapath and buffer
  typedef struct packed {
    logic loadCfg;   // accepted start: capture K, f1, f2, swap banks
    logic initRec;   // seed the recurrence registers
    logic stepRec;   // advance the recurrence by one word
    logic emitWord;  // register the current lane outputs
    logic emitLast;  // the word being emitted is the final one
  } ctrlStrobeT;

endpackage

// File: rtl/turbo_perm_ctrl.sv
module turbo_perm_ctrl
  import turbo_perm_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] blkLen,
  output ctrlStrobeT       strobe
);

  localparam int LB    = $clog2(LANES);
  localparam int CNT_W = IDX_W - LB;

  genStateT         state;
  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] lastWord;

  always_comb begin
    strobe          = '0;
    strobe.loadCfg  = (state == ST_IDLE) && start;
    strobe.initRec  = (state == ST_INIT);
    strobe.stepRec  = (state == ST_RUN);
    strobe.emitWord = (state == ST_RUN);
    strobe.emitLast = (state == ST_RUN) && (wordCnt == lastWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordCnt  <= '0;
      lastWord <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          lastWord <= blkLen[IDX_W-1:LB] - CNT_W'(1);
          state    <= ST_INIT;
        end
        ST_INIT: begin
          wordCnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          if (wordCnt == lastWord) state <= ST_IDLE;
          else wordCnt <= wordCnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_TO_INIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |=> strobe.initRec); // R2

  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCfg, strobe.initRec, strobe.emitWord})); // R2

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitLast |=> (state == ST_IDLE) && !strobe.emitWord); // R5

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && !strobe.emitLast) |=> (state == ST_RUN)); // R6

endmodule

// File: rtl/turbo_perm_idx_path.sv
module turbo_perm_idx_path
  import turbo_perm_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobe,
  input  logic [IDX_W-1:0]       blkLen,
  input  logic [IDX_W-1:0]       coefF1,
  input  logic [IDX_W-1:0]       coefF2,
  output logic [LANES*IDX_W-1:0] idxWord,
  output logic                   idxValid,
  output logic                   idxLast
);

  // captured configuration
  logic [IDX_W-1:0] cfgK, cfgF1, cfgF2;
  // recurrence state, always below cfgK
  logic [IDX_W-1:0] piBase, gBase, dStep;
  logic [IDX_W-1:0] gInit, dInit;

  // chained lane values: lanePi[j] = pi(base+j), laneG[j] = g(base+j)
  logic [IDX_W-1:0] lanePi [LANES+1];
  logic [IDX_W-1:0] laneG  [LANES+1];

  // a + b mod k, valid when a < k and b < k
  function automatic logic [IDX_W-1:0] modAdd(input logic [IDX_W-1:0] a,
                                              input logic [IDX_W-1:0] b,
                                              input logic [IDX_W-1:0] k);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, k}) s = s - {1'b0, k};
    return s[IDX_W-1:0];
  endfunction

  assign gInit = modAdd(cfgF1, cfgF2, cfgK);  // g(0) = f1 + f2
  assign dInit = modAdd(cfgF2, cfgF2, cfgK);  // g(i+1) - g(i) = 2 f2

  assign lanePi[0] = piBase;
  assign laneG[0]  = gBase;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lanePi[j+1] = modAdd(lanePi[j], laneG[j], cfgK);
    assign laneG[j+1]  = modAdd(laneG[j], dStep, cfgK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgK  <= '0;
      cfgF1 <= '0;
      cfgF2 <= '0;
    end else if (strobe.loadCfg) begin
      cfgK  <= blkLen;
      cfgF1 <= coefF1;
      cfgF2 <= coefF2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      piBase <= '0;
      gBase  <= '0;
      dStep  <= '0;
    end else if (strobe.initRec) begin
      piBase <= '0;
      gBase  <= gInit;
      dStep  <= dInit;
    end else if (strobe.stepRec) begin
      piBase <= lanePi[LANES];
      gBase  <= laneG[LANES];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxWord  <= '0;
      idxValid <= 1'b0;
      idxLast  <= 1'b0;
    end else begin
      idxValid <= strobe.emitWord;
      idxLast  <= strobe.emitLast;
      if (strobe.emitWord) begin
        for (int j = 0; j < LANES; j++) idxWord[j*IDX_W +: IDX_W] <= lanePi[j];
      end
    end
  end

  AST_STATE_REDUCED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepRec |-> (piBase < cfgK) && (gBase < cfgK) && (dStep < cfgK)); // R3

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    idxLast |-> idxValid); // R5

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCfg |=> $stable(cfgK) && $stable(cfgF1) && $stable(cfgF2)); // R10

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    AST_LANE_BELOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
      idxValid |-> (idxWord[j*IDX_W +: IDX_W] < cfgK)); // R4
  end

endmodule

// File: rtl/turbo_perm_bitbuf.sv
module turbo_perm_bitbuf #(
  parameter int LANES = 8,
  parameter int IDX_W = 13,
  parameter int WORDS = 768,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   swapBank,
  input  logic                   wrEn,
  input  logic [AW-1:0]          wrAddr,
  input  logic [LANES-1:0]       wrData,
  input  logic [LANES*IDX_W-1:0] rdIdx,
  input  logic                   rdValid,
  input  logic                   rdLast,
  output logic [LANES-1:0]       bitsOut,
  output logic                   bitsValid,
  output logic                   bitsLast
);

  localparam int LB = $clog2(LANES);

  logic [LANES-1:0] bankMem [2][WORDS];
  logic             fillBank;
  logic             readBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillBank <= 1'b0;
      readBank <= 1'b0;
    end else if (swapBank) begin
      readBank <= fillBank;
      fillBank <= ~fillBank;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) bankMem[fillBank][wrAddr] <= wrData;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_rd
    logic [IDX_W-1:0] laneIdx;
    assign laneIdx = rdIdx[j*IDX_W +: IDX_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bitsOut[j] <= 1'b0;
      else if (rdValid)
        bitsOut[j] <= bankMem[readBank][laneIdx[LB+AW-1:LB]][laneIdx[LB-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitsValid <= 1'b0;
      bitsLast  <= 1'b0;
    end else begin
      bitsValid <= rdValid;
      bitsLast  <= rdLast;
    end
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrAddr < AW'(WORDS))); // R8

  AST_BANKS_DIFFER: assert property (@(posedge clk) disable iff (!rstN)
    swapBank |=> (readBank != fillBank)); // R8

endmodule

// File: rtl/turbo_perm_gen.sv
module turbo_perm_gen
  import turbo_perm_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int IDX_W   = 13,
  parameter int MAX_LEN = 6144,
  localparam int WORDS  = MAX_LEN / LANES,
  localparam int AW     = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [IDX_W-1:0]       blkLen,
  input  logic [IDX_W-1:0]       coefF1,
  input  logic [IDX_W-1:0]       coefF2,
  input  logic                   wrEn,
  input  logic [AW-1:0]          wrAddr,
  input  logic [LANES-1:0]       wrData,
  output logic [LANES*IDX_W-1:0] idxWord,
  output logic                   idxValid,
  output logic                   idxLast,
  output logic [LANES-1:0]       permBits,
  output logic                   bitsValid,
  output logic                   bitsLast
);

  ctrlStrobeT strobe;

  turbo_perm_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .blkLen (blkLen),
    .strobe (strobe)
  );

  turbo_perm_idx_path #(.LANES(LANES), .IDX_W(IDX_W)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .blkLen   (blkLen),
    .coefF1   (coefF1),
    .coefF2   (coefF2),
    .idxWord  (idxWord),
    .idxValid (idxValid),
    .idxLast  (idxLast)
  );

  turbo_perm_bitbuf #(.LANES(LANES), .IDX_W(IDX_W), .WORDS(WORDS), .AW(AW)) buf_i (
    .clk       (clk),
    .rstN      (rstN),
    .swapBank  (strobe.loadCfg),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdIdx     (idxWord),
    .rdValid   (idxValid),
    .rdLast    (idxLast),
    .bitsOut   (permBits),
    .bitsValid (bitsValid),
    .bitsLast  (bitsLast)
  );

  AST_BITS_TRAIL_IDX: assert property (@(posedge clk) disable iff (!rstN)
    idxValid |=> bitsValid); // R7

  AST_BITS_LAST_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    idxLast |=> bitsLast); // R7

endmodule

// File: tb/turbo_perm_gen_tb_top.sv
`timescale 1ns/1ps
module turbo_perm_gen_tb_top;

  localparam int LANES = 8;
  localparam int IDX_W = 13;
  localparam int MAXK  = 6144;
  localparam int AW    = 10;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   start = 1'b0;
  logic [IDX_W-1:0]       blkLen = '0;
  logic [IDX_W-1:0]       coefF1 = '0;
  logic [IDX_W-1:0]       coefF2 = '0;
  logic                   wrEn = 1'b0;
  logic [AW-1:0]          wrAddr = '0;
  logic [LANES-1:0]       wrData = '0;
  logic [LANES*IDX_W-1:0] idxWord;
  logic                   idxValid, idxLast;
  logic [LANES-1:0]       permBits;
  logic                   bitsValid, bitsLast;

  always #10 clk = ~clk;  // 50 MHz

  turbo_perm_gen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .blkLen(blkLen),
    .coefF1(coefF1), .coefF2(coefF2), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .idxWord(idxWord), .idxValid(idxValid),
    .idxLast(idxLast), .permBits(permBits), .bitsValid(bitsValid),
    .bitsLast(bitsLast)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic longint permOf(input longint i, input longint k,
                                    input longint f1, input longint f2);
    return (f1 * i + f2 * i * i) % k;
  endfunction

  function automatic bit bitPat(input int p, input int seed);
    return ((p * 5 + seed * 3 + (p >> 3)) % 7) < 3;
  endfunction

  // behavioural reference state
  bit  modelMem [2][MAXK];
  bit  seen [MAXK];
  int  seenCnt = 0;
  bit  fillB = 0, rdB = 0;
  bit  busy = 0, newStart = 0;
  int  cyc = 0;
  longint mK = 8, mF1 = 0, mF2 = 0;
  int  mW = 1;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eV, eL, bV, bL;
      int n;
      if (newStart) begin busy = 1; cyc = 0; newStart = 0; end
      else if (busy) cyc++;
      eV = busy && cyc >= 2 && cyc <= mW + 1;
      eL = eV && (cyc == mW + 1);
      chk(idxValid === eV, "R2", "idxValid", idxValid, eV);
      chk(idxLast === eL, "R5", "idxLast", idxLast, eL);
      if (eV) begin
        n = cyc - 2;
        if (n == 0) begin
          for (int p = 0; p < MAXK; p++) seen[p] = 0;
          seenCnt = 0;
        end
        for (int j = 0; j < LANES; j++) begin
          longint e, a;
          e = permOf(n * LANES + j, mK, mF1, mF2);
          a = idxWord[j*IDX_W +: IDX_W];
          chk(a == e, "R3", "lane index", a, e);
          chk(a < mK, "R4", "index below K", a, mK);
          if (a < mK) begin
            chk(!seen[a], "R4", "index repeated", a, e);
            if (!seen[a]) seenCnt++;
            seen[a] = 1;
          end
        end
        if (eL) chk(seenCnt == mK, "R4", "distinct indices in block", seenCnt, mK);
      end
      bV = busy && cyc >= 3 && cyc <= mW + 2;
      bL = bV && (cyc == mW + 2);
      chk(bitsValid === bV, "R7", "bitsValid", bitsValid, bV);
      chk(bitsLast === bL, "R7", "bitsLast", bitsLast, bL);
      if (bV) begin
        n = cyc - 3;
        for (int j = 0; j < LANES; j++) begin
          bit eb;
          eb = modelMem[rdB][permOf(n * LANES + j, mK, mF1, mF2)];
          chk(permBits[j] === eb, "R7", "interleaved bit", permBits[j], eb);
        end
      end
      // inputs that the next rising edge samples
      if (wrEn) for (int b = 0; b < LANES; b++) modelMem[fillB][wrAddr * LANES + b] = wrData[b];
      if (start && (!busy || cyc >= mW + 1)) begin
        rdB = fillB;
        fillB = ~fillB;
        mK = blkLen; mF1 = coefF1; mF2 = coefF2;
        mW = blkLen / LANES;
        newStart = 1;
      end
    end
  end

  task automatic fillBlock(input int k, input int seed);
    for (int w = 0; w < k / LANES; w++) begin
      @(posedge clk); #2;
      wrEn = 1'b1;
      wrAddr = AW'(w);
      for (int b = 0; b < LANES; b++) wrData[b] = bitPat(w * LANES + b, seed);
    end
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic pulseStart(input int k, input int f1, input int f2);
    @(posedge clk); #2;
    blkLen = IDX_W'(k); coefF1 = IDX_W'(f1); coefF2 = IDX_W'(f2);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic waitBlock(input int k);
    repeat (k / LANES + 8) @(posedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(idxValid === 1'b0, "R1", "idxValid after reset", idxValid, 0);
    chk(idxLast === 1'b0, "R1", "idxLast after reset", idxLast, 0);
    chk(bitsValid === 1'b0, "R1", "bitsValid after reset", bitsValid, 0);
    chk(bitsLast === 1'b0, "R1", "bitsLast after reset", bitsLast, 0);

    // R2 R3: ordinary block
    fillBlock(40, 1);
    pulseStart(40, 3, 10);
    waitBlock(40);

    // R9: smallest block, one word carries last
    fillBlock(8, 2);
    pulseStart(8, 1, 2);
    waitBlock(8);

    // R6 R8 R10: during this block, change config, pulse start, fill other bank
    fillBlock(48, 3);
    pulseStart(48, 7, 12);
    @(posedge clk); #2;
    blkLen = 13'd16; coefF1 = 13'd5; coefF2 = 13'd4;
    start = 1'b1;                       // R6: must be ignored
    @(posedge clk); #2;
    start = 1'b0;
    fillBlock(64, 4);                   // R8: lands in the other bank
    waitBlock(48);
    pulseStart(64, 7, 16);              // reads data written mid-block
    waitBlock(64);

    // R9: largest block
    fillBlock(6144, 5);
    pulseStart(6144, 263, 480);
    waitBlock(6144);

    // second mid-size block after the large one
    fillBlock(1024, 6);
    pulseStart(1024, 31, 64);
    waitBlock(1024);

    finished = 1;
    summary();
    $finish;
  end

endmodule